// File: doc/BRIEF.md
# Multicycle Integer Datapath Controller

This block is a small non-pipelined integer processor core. Each instruction passes through a fixed sequence of steps: fetch, decode with register read, execute or address generation, memory access or branch resolution, and write-back. Every intermediate result is held in its own holding register. These are the instruction word, the incremented PC, the two source operands, the immediate, the ALU result, the branch condition and the loaded word. The instruction set covers word load, word store, branch-if-equal, register-register ALU operations and register-immediate ALU operations.

The core has two memory ports. The instruction port presents the PC and expects the instruction word back in the same cycle. The data port presents an address, write data and a write strobe, and expects read data in the same cycle. Stores, branches and unrecognised instructions take four cycles. All other instructions take five. The PC is updated at the end of the memory step.

Top module: `mc_core`

## Requirements
- R1: While reset is held, the instruction address equals the RESET_PC parameter and the data write strobe is low. After reset is released, the first cycle is a fetch of the word at RESET_PC, and all 32 registers read zero.
- R2: The fetch step reads the instruction at the current PC. Apart from branches, the next PC is the current PC plus 4.
- R3: The PC changes only at the end of the fourth cycle of an instruction. Stores (opcode 0100011), branches (1100011) and unrecognised opcodes take 4 cycles. Loads (0000011), register-register (0110011) and register-immediate (0010011) instructions take 5 cycles.
- R4: Register-register operations are selected by bits 14:12 (func3). The codes are 000 add, or subtract when bit 30 is set; 001 shift left; 010 signed less-than (result 1 or 0); 100 xor; 101 logical shift right; 110 or; 111 and. The shift amount is the low 5 bits of the second operand.
- R5: Register-immediate operations use the same func3 codes, with the second operand being bits 31:20 sign-extended. Code 000 always adds, whatever bit 30 holds.
- R6: func3 011 produces zero in both ALU forms. Code 101 shifts in zeros even when bit 30 is set.
- R7: A load reads the word at rs1 + sign-extended bits 31:20, and writes it to rd after the memory step. During the memory step the data address equals the computed address.
- R8: A store writes rs2 to address rs1 + the sign-extended immediate {bits 31:25, bits 11:7}. It does this with a single-cycle write strobe in its fourth cycle.
- R9: A branch compares rs1 and rs2. When they are equal, the next PC is PC + 4 + 4 × imm, where imm is the same split field as for stores, sign-extended. Otherwise the next PC is PC + 4.
- R10: Register 0 always reads zero. Writes to it are discarded.
- R11: An unrecognised opcode writes no register and stores nothing. It only moves the PC to PC + 4.
- R12: The data write strobe is high only in the memory step of a store, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | XLEN | Instruction fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word returned for imem_addr |
| dmem_addr | output | XLEN | Data access address |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Store strobe, one cycle |
| dmem_rdata | input | XLEN | Load data returned for dmem_addr |

## Verification
The bench builds the core with XLEN = 32, RESET_PC = 0x40 and BARREL_SHIFT = 1. The non-zero reset vector shows that fetch starts from the parameter rather than from address zero. Selecting the staged shifter exercises its per-bit stages with shift amounts up to 31, including the bit-30 variants of right shifts. Random programs of ALU, load, store, branch and unrecognised words run in lockstep with a bench model, with a register dump at the end of each program. This drives every func3 code, both polarities of each branch, and writes aimed at register 0.

// File: rtl/mc_pkg.sv
package mc_pkg;

   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_MEM    = 3'd3,
      ST_WB     = 3'd4
   } step_t;

   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_LOAD   = 3'd1,
      K_STORE  = 3'd2,
      K_BRANCH = 3'd3,
      K_REG    = 3'd4,
      K_IMM    = 3'd5
   } kind_t;

   typedef enum logic [3:0] {
      A_ADD, A_SUB, A_SLL, A_SLT, A_ZERO, A_XOR, A_SRL, A_OR, A_AND
   } alu_op_t;

   function automatic kind_t opc_kind(logic [6:0] opc);
      case (opc)
         OPC_LOAD:   return K_LOAD;
         OPC_STORE:  return K_STORE;
         OPC_BRANCH: return K_BRANCH;
         OPC_REG:    return K_REG;
         OPC_IMM:    return K_IMM;
         default:    return K_NONE;
      endcase
   endfunction

   function automatic alu_op_t func_op(logic [2:0] f3, logic alt, logic is_reg);
      case (f3)
         3'b000:  return (is_reg && alt) ? A_SUB : A_ADD;
         3'b001:  return A_SLL;
         3'b010:  return A_SLT;
         3'b011:  return A_ZERO;
         3'b100:  return A_XOR;
         3'b101:  return A_SRL;
         3'b110:  return A_OR;
         default: return A_AND;
      endcase
   endfunction

   function automatic logic writes_reg(kind_t k);
      return (k == K_LOAD) || (k == K_REG) || (k == K_IMM);
   endfunction

endpackage

// File: rtl/mc_immgen.sv
module mc_immgen
   import mc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     ir,
   input  kind_t           kind,
   output logic [XLEN-1:0] imm
);
   localparam int FIELD_W = 12;

   logic [FIELD_W-1:0] field;

   always_comb begin
      if (kind == K_STORE || kind == K_BRANCH)
         field = {ir[31:25], ir[11:7]};
      else
         field = ir[31:20];
   end

   assign imm = {{(XLEN-FIELD_W){field[FIELD_W-1]}}, field};
endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit BARREL_SHIFT = 1'b1
) (
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  alu_op_t         op,
   output logic [XLEN-1:0] res
);
   localparam int SHW = $clog2(XLEN);

   logic [SHW-1:0]  shamt;
   logic [XLEN-1:0] shl, shr;

   assign shamt = opb[SHW-1:0];

   generate
      if (BARREL_SHIFT) begin : g_staged
         logic [XLEN-1:0] lst [SHW+1];
         logic [XLEN-1:0] rst [SHW+1];
         assign lst[0] = opa;
         assign rst[0] = opa;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            assign lst[s+1] = shamt[s] ? (lst[s] << (1 << s)) : lst[s];
            assign rst[s+1] = shamt[s] ? (rst[s] >> (1 << s)) : rst[s];
         end
         assign shl = lst[SHW];
         assign shr = rst[SHW];
      end else begin : g_flat
         assign shl = opa << shamt;
         assign shr = opa >> shamt;
      end
   endgenerate

   always_comb begin
      case (op)
         A_ADD:   res = opa + opb;
         A_SUB:   res = opa - opb;
         A_SLL:   res = shl;
         A_SLT:   res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
         A_XOR:   res = opa ^ opb;
         A_SRL:   res = shr;
         A_OR:    res = opa | opb;
         A_AND:   res = opa & opb;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(NREG)-1:0] ra1,
   input  logic [$clog2(NREG)-1:0] ra2,
   output logic [XLEN-1:0]         rd1,
   output logic [XLEN-1:0]         rd2,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] wa,
   input  logic [XLEN-1:0]         wd
);
   localparam int AW = $clog2(NREG);

   logic [XLEN-1:0] rows [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_row
         if (i == 0) begin : g_zero
            assign rows[i] = '0;
         end else begin : g_store
            logic [XLEN-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (we && wa == AW'(i))
                  q <= wd;
            end
            assign rows[i] = q;
         end
      end
   endgenerate

   assign rd1 = rows[ra1];
   assign rd2 = rows[ra2];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  kind_t kind,
   output step_t step
);
   step_t nxt;

   always_comb begin
      case (step)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: nxt = ST_EXEC;
         ST_EXEC:   nxt = ST_MEM;
         ST_MEM:    nxt = writes_reg(kind) ? ST_WB : ST_FETCH;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step <= ST_FETCH;
      else        step <= nxt;
   end
endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter logic [XLEN-1:0] RESET_PC     = '0,
   parameter bit              BARREL_SHIFT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata
);
   localparam int NREG = 32;
   localparam int RAW  = $clog2(NREG);
   localparam logic [XLEN-1:0] STEP_BYTES = XLEN'(4);

   generate
      if (XLEN < 32 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("mc_core: XLEN must be a power of two of at least 32");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
         $error("mc_core: RESET_PC must be word aligned");
      end
   endgenerate

   step_t           step;
   kind_t           kind;
   logic [XLEN-1:0] pc_q, npc_q, a_q, b_q, imm_q, aluout_q, lmd_q;
   logic [31:0]     ir_q;
   logic            cond_q;
   logic [XLEN-1:0] imm_w, rf_a, rf_b, alu_a, alu_b, alu_y, wb_data;
   alu_op_t         alu_op;
   logic            rf_we;

   assign kind = opc_kind(ir_q[6:0]);

   mc_ctrl u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .kind (kind),
      .step (step)
   );

   mc_immgen #(.XLEN(XLEN)) u_imm (
      .ir  (ir_q),
      .kind(kind),
      .imm (imm_w)
   );

   assign rf_we   = (step == ST_WB) && writes_reg(kind);
   assign wb_data = (kind == K_LOAD) ? lmd_q : aluout_q;

   mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk  (clk),
      .rst_n(rst_n),
      .ra1  (ir_q[19:15]),
      .ra2  (ir_q[24:20]),
      .rd1  (rf_a),
      .rd2  (rf_b),
      .we   (rf_we),
      .wa   (ir_q[11:7]),
      .wd   (wb_data)
   );

   always_comb begin
      alu_a  = a_q;
      alu_b  = imm_q;
      alu_op = A_ADD;
      case (kind)
         K_BRANCH: begin
            alu_a = npc_q;
            alu_b = {imm_q[XLEN-3:0], 2'b00};
         end
         K_REG: begin
            alu_b  = b_q;
            alu_op = func_op(ir_q[14:12], ir_q[30], 1'b1);
         end
         K_IMM: alu_op = func_op(ir_q[14:12], ir_q[30], 1'b0);
         default: ;
      endcase
   end

   mc_alu #(.XLEN(XLEN), .BARREL_SHIFT(BARREL_SHIFT)) u_alu (
      .opa(alu_a),
      .opb(alu_b),
      .op (alu_op),
      .res(alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= RESET_PC;
         npc_q    <= '0;
         ir_q     <= '0;
         a_q      <= '0;
         b_q      <= '0;
         imm_q    <= '0;
         aluout_q <= '0;
         cond_q   <= 1'b0;
         lmd_q    <= '0;
      end else begin
         case (step)
            ST_FETCH: begin
               ir_q  <= imem_rdata;
               npc_q <= pc_q + STEP_BYTES;
            end
            ST_DECODE: begin
               a_q   <= rf_a;
               b_q   <= rf_b;
               imm_q <= imm_w;
            end
            ST_EXEC: begin
               aluout_q <= alu_y;
               cond_q   <= (a_q == b_q);
            end
            ST_MEM: begin
               pc_q <= (kind == K_BRANCH && cond_q) ? aluout_q : npc_q;
               if (kind == K_LOAD) lmd_q <= dmem_rdata;
            end
            default: ;
         endcase
      end
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = aluout_q;
   assign dmem_wdata = b_q;
   assign dmem_we    = (step == ST_MEM) && (kind == K_STORE);
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
   import mc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input step_t           step,
   input kind_t           kind,
   input logic [XLEN-1:0] pc_q,
   input logic [31:0]     ir_q,
   input logic [XLEN-1:0] a_q,
   input logic [31:0]     imem_rdata,
   input logic            dmem_we
);
   // R12
   we_in_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> step == ST_MEM);

   // R12
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |=> !dmem_we);

   // R3
   pc_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step != ST_MEM |=> $stable(pc_q));

   // R3
   short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_MEM && (kind == K_STORE || kind == K_BRANCH || kind == K_NONE))
      |=> step == ST_FETCH);

   // R3
   exec_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step == ST_EXEC |=> step == ST_MEM);

   // R2
   fetch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step == ST_FETCH |=> ir_q == $past(imem_rdata));

   // R10
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_DECODE && ir_q[19:15] == 5'd0) |=> a_q == '0);
endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step      (step),
   .kind      (kind),
   .pc_q      (pc_q),
   .ir_q      (ir_q),
   .a_q       (a_q),
   .imem_rdata(imem_rdata),
   .dmem_we   (dmem_we)
);

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb;
   localparam logic [31:0] RST_PC = 32'h40;
   localparam logic [6:0] O_L = 7'b0000011, O_S = 7'b0100011, O_B = 7'b1100011,
                          O_R = 7'b0110011, O_I = 7'b0010011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   logic [31:0] imem [512];
   logic [31:0] dmem [512];
   logic [31:0] mdm  [512];
   logic [31:0] mr   [32];
   string       mtag [32];
   logic [31:0] mpc;
   int          total = 0, bad = 0, wp = 0;
   bit          done = 1'b0;

   int          e_len;
   bit          e_store, e_load;
   logic [31:0] e_addr, e_data, e_next;
   string       e_dtag, e_ptag;

   always #2 clk = ~clk;

   mc_core #(.XLEN(32), .RESET_PC(RST_PC), .BARREL_SHIFT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata));

   assign imem_rdata = imem[imem_addr[10:2]];
   assign dmem_rdata = dmem[dmem_addr[10:2]];
   always @(posedge clk) if (dmem_we) dmem[dmem_addr[10:2]] <= dmem_wdata;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sx(input logic [11:0] v);
      return {{20{v[11]}}, v};
   endfunction
   function automatic logic [31:0] enc_r(input bit alt, input int rs2, input int rs1, input logic [2:0] f3, input int rd);
      return {1'b0, alt, 5'b0, 5'(rs2), 5'(rs1), f3, 5'(rd), O_R};
   endfunction
   function automatic logic [31:0] enc_i(input logic [11:0] im, input int rs1, input logic [2:0] f3, input int rd, input logic [6:0] opc);
      return {im, 5'(rs1), f3, 5'(rd), opc};
   endfunction
   function automatic logic [31:0] enc_s(input logic [11:0] im, input int rs2, input int rs1, input logic [6:0] opc);
      return {im[11:5], 5'(rs2), 5'(rs1), 3'b010, im[4:0], opc};
   endfunction

   function automatic logic [31:0] ref_alu(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f3, input bit sub);
      case (f3)
         3'd0: return sub ? a - b : a + b;
         3'd1: return a << b[4:0];
         3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         3'd3: return 32'd0;
         3'd4: return a ^ b;
         3'd5: return a >> b[4:0];
         3'd6: return a | b;
         default: return a & b;
      endcase
   endfunction

   // Bench model of one instruction: requirements R2..R11
   task automatic model_step();
      logic [31:0] ins, res, addr;
      int rd, rs1, rs2;
      logic [2:0] f3;
      string t;
      ins = imem[mpc[10:2]];
      rd = int'(ins[11:7]); rs1 = int'(ins[19:15]); rs2 = int'(ins[24:20]);
      f3 = ins[14:12];
      e_store = 0; e_load = 0; e_next = mpc + 4; e_ptag = "R2"; e_len = 5;
      case (ins[6:0])
         O_R, O_I: begin
            if (ins[6:0] == O_R) begin
               res = ref_alu(mr[rs1], mr[rs2], f3, ins[30]);
               t = "R4";
            end else begin
               res = ref_alu(mr[rs1], sx(ins[31:20]), f3, 1'b0);
               t = "R5";
            end
            if (f3 == 3'd3 || (f3 == 3'd5 && ins[30])) t = "R6";
            if (rd != 0) begin mr[rd] = res; mtag[rd] = t; end
         end
         O_L: begin
            addr = mr[rs1] + sx(ins[31:20]);
            e_load = 1; e_addr = addr;
            if (rd != 0) begin mr[rd] = mdm[addr[10:2]]; mtag[rd] = "R7"; end
         end
         O_S: begin
            addr = mr[rs1] + sx({ins[31:25], ins[11:7]});
            e_store = 1; e_addr = addr; e_data = mr[rs2]; e_dtag = mtag[rs2];
            mdm[addr[10:2]] = mr[rs2];
            e_len = 4;
         end
         O_B: begin
            if (mr[rs1] == mr[rs2]) e_next = mpc + 4 + (sx({ins[31:25], ins[11:7]}) << 2);
            e_ptag = "R9"; e_len = 4;
         end
         default: begin e_ptag = "R11"; e_len = 4; end
      endcase
      mr[0] = 32'd0;
   endtask

   task automatic run_one();
      logic [31:0] old;
      old = mpc;
      model_step();
      chk(imem_addr == old, "R2", imem_addr, old);
      for (int j = 1; j <= e_len; j++) begin
         @(posedge clk); @(negedge clk);
         if (j == 3) begin
            chk(dmem_we == e_store, "R12", 32'(dmem_we), 32'(e_store));
            chk(imem_addr == old, "R3", imem_addr, old);
            if (e_store) begin
               chk(dmem_addr == e_addr, "R8", dmem_addr, e_addr);
               chk(dmem_wdata == e_data, e_dtag, dmem_wdata, e_data);
            end
            if (e_load) chk(dmem_addr == e_addr, "R7", dmem_addr, e_addr);
         end else if (j < e_len) begin
            chk(dmem_we == 1'b0, "R12", 32'(dmem_we), 32'd0);
         end
         if (j == 4) chk(imem_addr == e_next, "R3", imem_addr, e_next);
      end
      chk(imem_addr == e_next, e_ptag, imem_addr, e_next);
      mpc = e_next;
   endtask

   task automatic put(input logic [31:0] w);
      imem[wp] = w;
      wp++;
   endtask

   task automatic start_prog();
      for (int i = 0; i < 512; i++) imem[i] = 32'd0;
      wp = int'(RST_PC[10:2]);
   endtask

   task automatic end_prog();
      for (int k = 0; k < 32; k++) put(enc_s(12'(4 * k), k, 0, O_S));
      put(enc_s(12'hFFF, 0, 0, O_B));
   endtask

   task automatic run_prog();
      logic [31:0] halt;
      int n;
      halt = 32'((wp - 1) * 4);
      for (int i = 0; i < 512; i++) begin
         dmem[i] = 32'(i * 7 + 3);
         mdm[i]  = 32'(i * 7 + 3);
      end
      for (int r = 0; r < 32; r++) begin mr[r] = 32'd0; mtag[r] = (r == 0) ? "R10" : "R1"; end
      mpc = RST_PC;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(imem_addr == RST_PC, "R1", imem_addr, RST_PC);
      chk(dmem_we == 1'b0, "R1", 32'(dmem_we), 32'd0);
      rst_n = 1'b1;
      n = 0;
      while (mpc != halt && n < 3000) begin
         run_one();
         n++;
      end
      chk(mpc == halt, "R2", mpc, halt);
   endtask

   task automatic rand_prog(input int count);
      int r, a, b, d;
      start_prog();
      for (int i = 0; i < count; i++) begin
         r = int'($urandom % 12);
         a = int'($urandom % 32); b = int'($urandom % 32); d = int'($urandom % 32);
         if (r < 4)       put(enc_r(1'($urandom), b, a, 3'($urandom), d));
         else if (r < 7)  put(enc_i(12'($urandom), a, 3'($urandom), d, O_I));
         else if (r == 7) put(enc_s(12'(512 + 4 * ($urandom % 256)), b, 0, O_S));
         else if (r == 8) put(enc_i(12'(512 + 4 * ($urandom % 256)), 0, 3'b010, d, O_L));
         else if (r == 9) put(enc_s(12'($urandom % 3), ($urandom % 2) ? a : b, a, O_B));
         else if (r == 10) put(enc_i(12'($urandom), a, 3'($urandom), d, 7'b1111111));
         else             put(enc_i(12'($urandom), 0, 3'b000, d, O_I));
      end
      end_prog();
      run_prog();
   endtask

   initial begin
      void'($urandom(32'h5EED));
      // Directed program: ALU corners, x0, load/store, both branch outcomes, unknown opcode
      start_prog();
      put(enc_i(12'hFFB, 0, 3'd0, 1, O_I));        // R5 x1 = -5
      put(enc_i(12'd7, 0, 3'd0, 2, O_I));          // x2 = 7
      put(enc_r(1'b0, 2, 1, 3'd0, 3));             // R4 add
      put(enc_r(1'b1, 2, 1, 3'd0, 4));             // R4 sub
      put(enc_r(1'b0, 2, 1, 3'd2, 5));             // R4 slt negative < positive
      put(enc_r(1'b0, 1, 2, 3'd2, 6));             // R4 slt false
      put(enc_i(12'd1, 0, 3'd0, 7, O_I));
      put(enc_i(12'd31, 7, 3'd1, 8, O_I));         // R5 shift to bit 31
      put(enc_i(12'd31, 8, 3'd5, 9, O_I));         // R5 srl by 31
      put(enc_i(12'h41F, 8, 3'd5, 10, O_I));       // R6 bit 30 set, still logical
      put(enc_r(1'b1, 7, 8, 3'd5, 11));            // R6 reg form, bit 30 set
      put(enc_i(12'h0F0, 1, 3'd4, 12, O_I));
      put(enc_i(12'h0F0, 1, 3'd6, 13, O_I));
      put(enc_i(12'h0F0, 1, 3'd7, 14, O_I));
      put(enc_r(1'b0, 2, 1, 3'd3, 15));            // R6 code 011 gives zero
      put(enc_i(12'd5, 0, 3'd0, 0, O_I));          // R10 write to x0
      put(enc_r(1'b0, 0, 0, 3'd0, 16));            // R10 reads of x0
      put(enc_i(12'd100, 0, 3'd0, 17, O_I));
      put(enc_s(12'hFFC, 2, 17, O_S));             // R8 negative store offset
      put(enc_i(12'hFFC, 17, 3'b010, 18, O_L));    // R7 load back
      put(enc_s(12'd1, 2, 1, O_B));                // R9 not taken
      put(enc_s(12'd1, 18, 2, O_B));               // R9 taken, skips next
      put(enc_i(12'd99, 0, 3'd0, 19, O_I));
      put(32'hFFFF_FFFF);                          // R11 unknown opcode
      put(enc_r(1'b0, 7, 2, 3'd1, 20));            // R4 sll
      put(enc_s(12'd2, 0, 0, O_B));                // R9 forward taken over two
      put(enc_i(12'd1, 0, 3'd0, 21, O_I));
      put(enc_i(12'd2, 0, 3'd0, 22, O_I));
      end_prog();
      run_prog();
      for (int p = 0; p < 4; p++) rand_prog(80);
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule